// File: doc/BRIEF.md
# Reduced Hamming Check Bit Predictor

This block produces the check bits that guard the output word of a piece of combinational logic so that errors can be detected while the logic is in normal use. Each check bit is the XOR of a chosen subset of the protected outputs. Column j of an M-row by K-column parity matrix says which outputs belong to check bit j. The matrix is fixed when the design is elaborated. The protected word and its predicted check bits are registered on the same clock edge, so they always leave the block as one aligned code word.

The default matrix follows a fixed construction. The first column is all ones, so check bit 0 is the even parity of the whole word. The last column selects the outputs at the odd 1-based row positions. Every column after the first has as many ones as zeros. Rows are distinct, so the pattern of failing check bits points at the faulty output in the manner of a binary search. A parameter reduces the block to a single even parity bit.

A built-in comparator serves as a reference for the bench. It recomputes the check bits of a received word and forms a syndrome against the supplied check bits. It raises a mismatch flag when the two differ. When the syndrome equals exactly one row code, it also names the output that explains the error.

Top module: `chk_bit_predictor`

## Requirements
- R1: While `rst_n` is low, every registered output (`pred_word`, `pred_chk`, `syndrome`, `mismatch`, `loc_hit`, `loc_idx`) reads zero at the next clock edge.
- R2: One cycle after `func_word` is applied, `pred_chk[j]` equals the XOR of the bits `func_word[i]` for which matrix cell (row i, column j) is 1. With the defaults M=8 and K=4, column masks over bit i are: column 0 = 8'hFF, column 1 = 8'h0F, column 2 = 8'h33, column 3 = 8'h55. Equivalently, row i has code {~i[0], ~i[1], ~i[2], 1} as pred_chk[3:0].
- R3: `pred_word` shows the `func_word` sampled at the same edge that produced `pred_chk`, so the word and its check bits change together.
- R4: `pred_chk[0]` is the even parity (XOR) of all bits of `pred_word`.
- R5: The matrix in use obeys the construction rules, and elaboration stops with an error otherwise. Column 0 is all ones. The last column is 1 exactly at even bit indices. Every column after the first has M/2 ones. Rows are pairwise distinct. M <= 2^K - K - 1, so 8 outputs need at least 4 check bits.
- R6: One cycle after a received pair is applied with `rx_chk_present` high, `mismatch` is 1 exactly when the recomputed check bits of `rx_word` differ from `rx_chk`.
- R7: With `rx_chk_present` low, `rx_chk` is ignored. The supplied check bits are taken as zero, so `syndrome` equals the recomputed check bits of `rx_word`, and `mismatch` is 1 when any of them is 1.
- R8: `syndrome` is the bitwise XOR of the recomputed and the supplied check bits, registered with `mismatch`.
- R9: When `syndrome` equals the row code of exactly one output i, `loc_hit` is 1 and `loc_idx` is i. Otherwise both are 0, which includes any syndrome with bit 0 clear. In single parity mode `loc_hit` stays 0.
- R10: With `SINGLE_PARITY` = 1, the block has one check bit, equal to the XOR of all outputs, and the comparator uses that single bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_word | input | M | Output word of the protected logic |
| rx_word | input | M | Word presented to the reference comparator |
| rx_chk | input | CW | Check bits supplied with `rx_word` (CW = 1 in single parity mode, else K) |
| rx_chk_present | input | 1 | High when `rx_chk` is valid; low compares against zero |
| pred_word | output | M | Registered copy of `func_word` |
| pred_chk | output | CW | Registered predicted check bits of `func_word` |
| syndrome | output | CW | Registered recomputed-versus-supplied difference |
| mismatch | output | 1 | Registered: syndrome is nonzero |
| loc_hit | output | 1 | Registered: syndrome matches one row code |
| loc_idx | output | max(1, clog2 M) | Registered index of the matching output |

## Verification
Every single output in turn is set to one. The predicted bits then equal that row's code, which exposes a wrong column mask or a row-to-column transpose at once. Words with one flipped output must locate that output. Words with two flipped outputs must raise the mismatch flag without a location, and a locator that matched on partial codes would wrongly report a hit. Corrupting only check bit 0 gives syndrome 4'b0001, which is also the code of output 7. A design that treated check-bit faults specially would disagree with the bench here. Garbage on `rx_chk` with the present flag low must leave the syndrome equal to the recomputed bits. A comparator that used the supplied bits anyway would show a different syndrome.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

  // Default construction cell: column 0 all ones, column c>0 is the
  // inverse of row-index bit (k-1-c), which makes the last column select
  // even bit indices and keeps every other column balanced.
  function automatic bit col_cell(int row, int col, int k);
    if (col == 0) return 1'b1;
    return ((row >> (k - 1 - col)) & 1) == 0;
  endfunction

  // Hamming bound on the number of data bits a k-bit check word covers.
  function automatic bit hamming_fits(int m, int k);
    return m <= ((1 << k) - k - 1);
  endfunction

endpackage

// File: rtl/cbp_parity_tree.sv
module cbp_parity_tree #(
  parameter int M  = 8,
  parameter int CW = 4,
  parameter logic [CW*M-1:0] MAT = '1
) (
  input  logic [M-1:0]  word,
  output logic [CW-1:0] chk
);

  // One XOR reduction per matrix column.
  for (genvar c = 0; c < CW; c++) begin : g_col
    localparam logic [M-1:0] MASK = MAT[c*M +: M];
    assign chk[c] = ^(word & MASK);
  end

endmodule

// File: rtl/cbp_locator.sv
module cbp_locator #(
  parameter int M  = 8,
  parameter int CW = 4,
  parameter int IW = 3,
  parameter logic [CW*M-1:0] MAT = '1,
  parameter bit ENABLE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] syn,
  output logic          hit,
  output logic [IW-1:0] idx
);

  function automatic logic [CW-1:0] row_code(int r);
    logic [CW-1:0] v;
    for (int c = 0; c < CW; c++) v[c] = MAT[c*M + r];
    return v;
  endfunction

  logic [M-1:0] row_hit;

  for (genvar r = 0; r < M; r++) begin : g_row
    localparam logic [CW-1:0] RC = row_code(r);
    assign row_hit[r] = ENABLE && (syn == RC);
  end

  always_comb begin
    idx = '0;
    for (int r = 0; r < M; r++)
      if (row_hit[r]) idx = idx | IW'(r);
  end

  assign hit = |row_hit;

  // R9: distinct row codes mean at most one row can match a syndrome.
  p_rows_unique_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_hit))
    else $error("p_rows_unique_r9: several rows match one syndrome");

endmodule

// File: rtl/chk_bit_predictor.sv
module chk_bit_predictor #(
  parameter int M = 8,
  parameter int K = 4,
  parameter bit SINGLE_PARITY = 1'b0,
  parameter logic [K*M-1:0] COLS = '0,
  localparam int CW = SINGLE_PARITY ? 1 : K,
  localparam int IW = (M > 1) ? $clog2(M) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [M-1:0]  func_word,
  input  logic [M-1:0]  rx_word,
  input  logic [CW-1:0] rx_chk,
  input  logic          rx_chk_present,
  output logic [M-1:0]  pred_word,
  output logic [CW-1:0] pred_chk,
  output logic [CW-1:0] syndrome,
  output logic          mismatch,
  output logic          loc_hit,
  output logic [IW-1:0] loc_idx
);

  // Matrix in use: all-ones column in single parity mode, the built-in
  // construction when COLS is left at zero, otherwise COLS itself.
  function automatic logic [CW*M-1:0] pick_matrix();
    logic [CW*M-1:0] v;
    for (int c = 0; c < CW; c++)
      for (int r = 0; r < M; r++)
        if (SINGLE_PARITY)   v[c*M + r] = 1'b1;
        else if (COLS == '0) v[c*M + r] = cbp_pkg::col_cell(r, c, K);
        else                 v[c*M + r] = COLS[c*M + r];
    return v;
  endfunction

  localparam logic [CW*M-1:0] MAT = pick_matrix();

  // R5: construction rules evaluated on the matrix in use.
  function automatic bit rules_ok();
    int ones;
    bit same;
    if (SINGLE_PARITY) return 1'b1;
    if (!cbp_pkg::hamming_fits(M, K)) return 1'b0;
    for (int r = 0; r < M; r++) begin
      if (!MAT[r]) return 1'b0;
      if (MAT[(CW-1)*M + r] != ((r % 2) == 0)) return 1'b0;
    end
    for (int c = 1; c < CW; c++) begin
      ones = 0;
      for (int r = 0; r < M; r++) ones += int'(MAT[c*M + r]);
      if (2 * ones != M) return 1'b0;
    end
    for (int a = 0; a < M; a++)
      for (int b = a + 1; b < M; b++) begin
        same = 1'b1;
        for (int c = 0; c < CW; c++)
          if (MAT[c*M + a] != MAT[c*M + b]) same = 1'b0;
        if (same) return 1'b0;
      end
    return 1'b1;
  endfunction

  localparam bit RULES_OK = rules_ok();

  if (!RULES_OK) begin : g_rule_fail_r5
    $error("chk_bit_predictor: parity matrix breaks the construction rules (R5)");
  end

  // Prediction path.
  logic [CW-1:0] pred_chk_d;

  cbp_parity_tree #(.M(M), .CW(CW), .MAT(MAT)) u_pred_tree (
    .word (func_word),
    .chk  (pred_chk_d)
  );

  // Reference comparator path.
  logic [CW-1:0] rx_rec;
  logic [CW-1:0] rx_sup;
  logic [CW-1:0] syn_d;
  logic          loc_hit_d;
  logic [IW-1:0] loc_idx_d;

  cbp_parity_tree #(.M(M), .CW(CW), .MAT(MAT)) u_rx_tree (
    .word (rx_word),
    .chk  (rx_rec)
  );

  assign rx_sup = rx_chk_present ? rx_chk : '0;
  assign syn_d  = rx_rec ^ rx_sup;

  cbp_locator #(
    .M(M), .CW(CW), .IW(IW), .MAT(MAT), .ENABLE(!SINGLE_PARITY)
  ) u_locator (
    .clk   (clk),
    .rst_n (rst_n),
    .syn   (syn_d),
    .hit   (loc_hit_d),
    .idx   (loc_idx_d)
  );

  // Word and check bits share one register stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_word <= '0;
      pred_chk  <= '0;
      syndrome  <= '0;
      mismatch  <= 1'b0;
      loc_hit   <= 1'b0;
      loc_idx   <= '0;
    end else begin
      pred_word <= func_word;
      pred_chk  <= pred_chk_d;
      syndrome  <= syn_d;
      mismatch  <= |(rx_rec ^ rx_sup);
      loc_hit   <= loc_hit_d;
      loc_idx   <= loc_idx_d;
    end
  end

  // R1: reset clears every registered output.
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (pred_word == '0 && pred_chk == '0 && syndrome == '0 &&
                !mismatch && !loc_hit && loc_idx == '0))
    else $error("p_reset_clear_r1: outputs not cleared by reset");

  // R4 / R10: check bit 0 is the parity of the aligned word.
  p_chk0_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pred_chk[0] == ^pred_word)
    else $error("p_chk0_parity_r4: check bit 0 not word parity");

  // R8: comparator and predictor agree when fed the same word.
  p_syn_consistent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_chk_present && rx_word == func_word) |=>
      (syndrome == ($past(rx_chk) ^ pred_chk)))
    else $error("p_syn_consistent_r8: syndrome differs from predicted xor supplied");

  // R7: absent check bits leave only the recomputed bits.
  p_absent_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_chk_present && rx_word == func_word) |=> (syndrome == pred_chk))
    else $error("p_absent_ignored_r7: supplied bits used while absent");

  // R6: mismatch flag follows a nonzero syndrome.
  p_mismatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch == (syndrome != '0))
    else $error("p_mismatch_r6: mismatch flag and syndrome disagree");

  // R9: a located output always implies a mismatch and an odd-parity syndrome.
  p_loc_mismatch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loc_hit |-> (mismatch && syndrome[0]))
    else $error("p_loc_mismatch_r9: location without odd syndrome");

  // R9: no location report means a zero index.
  p_loc_idx_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_hit |-> (loc_idx == '0))
    else $error("p_loc_idx_zero_r9: stale index without a hit");

endmodule

// File: tb/tb_chk_bit_predictor.sv
module tb_chk_bit_predictor;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic [7:0] func_word, rx_word;
  logic [3:0] rx_chk;
  logic       rx_chk_present;

  logic [7:0] pred_word;
  logic [3:0] pred_chk, syndrome;
  logic       mismatch, loc_hit;
  logic [2:0] loc_idx;

  logic [7:0] sp_word;
  logic [0:0] sp_chk, sp_syn;
  logic       sp_mis, sp_hit;
  logic [2:0] sp_idx;

  chk_bit_predictor dut (
    .clk(clk), .rst_n(rst_n), .func_word(func_word), .rx_word(rx_word),
    .rx_chk(rx_chk), .rx_chk_present(rx_chk_present),
    .pred_word(pred_word), .pred_chk(pred_chk), .syndrome(syndrome),
    .mismatch(mismatch), .loc_hit(loc_hit), .loc_idx(loc_idx)
  );

  chk_bit_predictor #(.SINGLE_PARITY(1'b1)) dut_sp (
    .clk(clk), .rst_n(rst_n), .func_word(func_word), .rx_word(rx_word),
    .rx_chk(rx_chk[0:0]), .rx_chk_present(rx_chk_present),
    .pred_word(sp_word), .pred_chk(sp_chk), .syndrome(sp_syn),
    .mismatch(sp_mis), .loc_hit(sp_hit), .loc_idx(sp_idx)
  );

  typedef struct {
    logic [7:0] word;
    logic [3:0] chk;
    logic [3:0] syn;
    logic       mis;
    logic       hit;
    logic [2:0] idx;
    logic       p_chk;
    logic       p_syn;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Row-wise model of the code: row i -> {~i[0], ~i[1], ~i[2], 1}.
  function automatic logic [3:0] code_of(int i);
    logic [2:0] b;
    b = i[2:0];
    return {~b[0], ~b[1], ~b[2], 1'b1};
  endfunction

  function automatic logic [3:0] enc(logic [7:0] w);
    logic [3:0] acc = 4'd0;
    for (int i = 0; i < 8; i++) if (w[i]) acc = acc ^ code_of(i);
    return acc;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
    end
  endtask

  task automatic send(logic [7:0] fw, logic [7:0] rw, logic [3:0] rc, logic pres);
    exp_t e;
    logic [3:0] s;
    logic       ps;
    @(negedge clk);
    func_word = fw; rx_word = rw; rx_chk = rc; rx_chk_present = pres;
    s  = enc(rw) ^ (pres ? rc : 4'd0);
    ps = (^rw) ^ (pres ? rc[0] : 1'b0);
    e.word = fw; e.chk = enc(fw); e.syn = s; e.mis = (s != 0);
    e.hit = 1'b0; e.idx = 3'd0;
    for (int i = 0; i < 8; i++)
      if (s == code_of(i)) begin e.hit = 1'b1; e.idx = 3'(i); end
    e.p_chk = ^fw; e.p_syn = ps;
    @(posedge clk);
    #1;
    q.push_back(e);
  endtask

  // Monitor: one expected item per cycle, compared at the falling edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(pred_word == e.word, "R3", "pred_word", pred_word, e.word);
      check(pred_chk == e.chk, "R2", "pred_chk", pred_chk, e.chk);
      check(pred_chk[0] == ^e.word, "R4", "chk0 parity", pred_chk[0], ^e.word);
      check(syndrome == e.syn, "R8", "syndrome", syndrome, e.syn);
      check(mismatch == e.mis, "R6", "mismatch", mismatch, e.mis);
      check(loc_hit == e.hit, "R9", "loc_hit", loc_hit, e.hit);
      check(loc_idx == e.idx, "R9", "loc_idx", loc_idx, e.idx);
      check(sp_chk[0] == e.p_chk, "R10", "single parity chk", sp_chk, e.p_chk);
      check(sp_syn[0] == e.p_syn && sp_mis == e.p_syn, "R10", "single parity mismatch",
            sp_mis, e.p_syn);
      check(!sp_hit, "R10", "single parity loc_hit", sp_hit, 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    logic [7:0]  w;
    rst_n = 1'b0;
    func_word = 8'hA5; rx_word = 8'h3C; rx_chk = 4'hF; rx_chk_present = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state despite nonzero inputs
    check(pred_word == 0 && pred_chk == 0, "R1", "pred after reset",
          {pred_word, pred_chk}, 0);
    check(syndrome == 0 && !mismatch && !loc_hit && loc_idx == 0, "R1",
          "comparator after reset", {syndrome, mismatch, loc_hit, loc_idx}, 0);
    check(sp_chk == 0 && !sp_mis, "R1", "single parity after reset", {sp_chk, sp_mis}, 0);
    rst_n = 1'b1;

    // R2 / R5: one-hot words expose each row of the matrix
    for (int i = 0; i < 8; i++) send(8'(1 << i), 8'(1 << i), code_of(i), 1'b1);
    // R4: extremes
    send(8'h00, 8'h00, 4'h0, 1'b1);
    send(8'hFF, 8'hFF, enc(8'hFF), 1'b1);

    // R3 / R6: back-to-back clean words, no mismatch expected
    lf = 16'hACE1;
    for (int n = 0; n < 40; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      w = lf[7:0];
      send(w, w, enc(w), 1'b1);
    end

    // R9: single flipped output is located
    for (int i = 0; i < 8; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      w = lf[7:0];
      send(w, w ^ 8'(1 << i), enc(w), 1'b1);
    end

    // R9 / R6: double flip gives mismatch without location
    send(8'h5A, 8'h5A ^ 8'h03, enc(8'h5A), 1'b1);
    send(8'h11, 8'h11 ^ 8'h90, enc(8'h11), 1'b1);

    // R8: only check bits corrupted (bit 0 alone aliases output 7)
    for (int b = 0; b < 4; b++) send(8'hC3, 8'hC3, enc(8'hC3) ^ 4'(1 << b), 1'b1);

    // R7: absent check bits, garbage on rx_chk must be ignored
    send(8'h00, 8'h00, 4'hF, 1'b0);
    send(8'h6B, 8'h6B, 4'hA, 1'b0);
    send(8'h80, 8'h80, 4'h1, 1'b0);

    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule